// File: doc/BRIEF.md
# Disk Attachment Command Issue Sequencer

This block is the host-side engine that hands one command to a disk attachment over a small register bus. A start strobe latches the command fields: command code, device number, option byte, a short/long select, three argument words, the attention type and two mode bits. The block then runs the attention handshake. It turns attachment interrupts off, polls the status register until the attachment stops reporting busy, writes the attention byte, and turns interrupts back on.

After the handshake it writes the command words one at a time into the command register. After each word it polls the status register until the attachment has taken the word. Both polling loops are bounded. When a limit runs out, the sequence stops at once and the cause is reported together with the completion pulse.

Two mode inputs shape the handshake. One skips the not-busy wait, which is used when the attention acknowledges a reset-completion interrupt. The other ends the sequence after the handshake without sending any command words, which is used for an end-of-interrupt style attention.

Top module: `dsk_cmd_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), bus_req, done, busy_to, cmd_to and active are all 0.
- R2: A sequence starts with a byte write of 0x00 to the control register (address 0). It then makes byte reads of the status register (address 1) until status bit 0 (busy) reads 0. Next comes a byte write of the attention register (address 2), and then a byte write of 0x01 to the control register.
- R3: The busy poll counts only acknowledged status reads and allows at most POLL_LIMIT of them (default 10000). If all POLL_LIMIT reads show busy, the sequence ends with done and busy_to, and writes neither the attention register nor the interrupt enable.
- R4: When skip_wait is 1, the attention register write follows the interrupt-disable write with no status read in between.
- R5: The attention byte has the device number in bits 7:5 and the attention type in bits 4:0; the upper byte of bus_wdata is 0.
- R6: Command word 0 is the option byte in bits 15:8, ORed with 0x4000 when long_cmd is 1, the device number in bits 7:5 and the command code in bits 4:0.
- R7: A short command sends 2 words and a long command sends 4. Word k (k ≥ 1) is arg_words[16k-1:16k-16]. All command words are word-size writes to address 3.
- R8: After each command word the block reads status until bit 1 (command register full) reads 0. This poll allows at most POLL_LIMIT acknowledged reads. If all of them show full, the sequence ends with done and cmd_to, and no further word is sent.
- R9: When attn_only is 1, the sequence ends after the interrupt-enable write and sends no command words.
- R10: done is a one-cycle pulse at the end of every sequence. busy_to and cmd_to are only ever 1 together with done, and never both at once. active is 1 from the cycle after an accepted start up to and including the done cycle.
- R11: A start pulse while active is 1 is ignored: it does not change the sequence in progress and does not produce a second done.
- R12: The block holds bus_req, bus_we, bus_addr and bus_wdata steady until bus_ack. bus_word is 1 only for command-register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| cmd_code | input | 5 | Command code for word 0 |
| dev_num | input | 3 | Target device number |
| opt_byte | input | 8 | Option byte for word 0 |
| long_cmd | input | 1 | 1 = four-word command, 0 = two-word |
| attn_type | input | 5 | Attention type code |
| skip_wait | input | 1 | Skip the not-busy poll |
| attn_only | input | 1 | Stop after the attention handshake |
| arg_words | input | 48 | Command words 1..3, word 1 in the low 16 bits |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | output | 2 | Register address |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Access accepted this cycle (read data valid) |
| bus_rdata | input | 8 | Status byte returned on reads |
| active | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| busy_to | output | 1 | Not-busy poll ran out (valid with done) |
| cmd_to | output | 1 | Command-full poll ran out (valid with done) |

## Verification
The hardest cases to reach are the exact poll-limit edges. These are a flag that clears on the very last permitted read, which must still succeed, and a flag that stays set one read longer, which must abort. Each needs thousands of acknowledged reads, while the bus model also withholds acknowledge on random cycles. The bench's status model counts down a programmed number of busy or full reads per phase, reloading the full count on every command-word write. Directed runs then place that count at POLL_LIMIT-1 and POLL_LIMIT for both the handshake poll and a mid-command word poll. Random runs mix short waits, both command lengths, both mode bits and a start pulse injected mid-sequence.

// File: rtl/dsk_seq_pkg.sv
// Shared definitions for the disk command issue sequencer: register
// addresses, status bit positions, control values and the state encoding.
// Assumes a two-bit register address space on the host register bus.
package dsk_seq_pkg;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_ATTN = 2'd2,
        RA_CMDW = 2'd3
    } reg_addr_e;

    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_CFULL_BIT = 1;
    localparam logic [7:0] CTRL_IRQ_OFF = 8'h00;
    localparam logic [7:0] CTRL_IRQ_ON  = 8'h01;
    localparam int LONG_FLAG_BIT  = 14;

    typedef enum logic [2:0] {
        S_IDLE,
        S_IRQ_OFF,
        S_WAIT_IDLE,
        S_ATTN,
        S_IRQ_ON,
        S_WORD,
        S_WAIT_TAKEN,
        S_FIN
    } seq_st_e;

endpackage

// File: rtl/dsk_seq_pollctr.sv
// Bounded poll counter. Counts flag-set polls and reports when the current
// poll is the last one permitted. Assumes LIMIT >= 1; held clear outside a
// poll phase.
module dsk_seq_pollctr #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count the polls that saw the flag still set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end

    // The poll in flight is the LIMIT-th one.
    assign at_limit = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/dsk_seq_words.sv
// Command word selector. Builds word 0 from the latched fields and picks
// word idx for the command register. Assumes idx never exceeds last_idx.
module dsk_seq_words
    import dsk_seq_pkg::*;
#(
    parameter int NARG = 3
) (
    input  logic [4:0]         cmd_code,
    input  logic [2:0]         dev_num,
    input  logic [7:0]         opt_byte,
    input  logic               long_cmd,
    input  logic [16*NARG-1:0] arg_words,
    input  logic [1:0]         idx,
    output logic [15:0]        word,
    output logic [1:0]         last_idx
);
    logic [15:0] w [NARG+1];

    // Word 0: option byte, length flag, device and command code.
    always_comb begin
        w[0] = {opt_byte, 8'h00} | {8'h00, dev_num, cmd_code};
        if (long_cmd) w[0][LONG_FLAG_BIT] = 1'b1;
    end

    genvar k;
    generate
        for (k = 1; k <= NARG; k++) begin : g_arg
            assign w[k] = arg_words[16*k-1 -: 16];
        end
    endgenerate

    assign word     = w[idx];
    assign last_idx = long_cmd ? 2'd3 : 2'd1;
endmodule

// File: rtl/dsk_cmd_seq.sv
// Disk attachment command issue sequencer. Runs the attention handshake
// (interrupts off, bounded not-busy poll, attention byte, interrupts on)
// and then writes 2 or 4 command words, polling acceptance of each with
// its own bounded count. Assumes a request/acknowledge register bus where
// read data is valid in the acknowledge cycle.
module dsk_cmd_seq
    import dsk_seq_pkg::*;
#(
    parameter int POLL_LIMIT = 10000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  cmd_code,
    input  logic [2:0]  dev_num,
    input  logic [7:0]  opt_byte,
    input  logic        long_cmd,
    input  logic [4:0]  attn_type,
    input  logic        skip_wait,
    input  logic        attn_only,
    input  logic [47:0] arg_words,
    output logic        bus_req,
    output logic        bus_we,
    output logic        bus_word,
    output logic [1:0]  bus_addr,
    output logic [15:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [7:0]  bus_rdata,
    output logic        active,
    output logic        done,
    output logic        busy_to,
    output logic        cmd_to
);
    seq_st_e     st;
    logic [4:0]  r_cmd;
    logic [2:0]  r_dev;
    logic [7:0]  r_opt;
    logic        r_long;
    logic [4:0]  r_attn;
    logic        r_skip;
    logic        r_aonly;
    logic [47:0] r_args;
    logic [1:0]  widx;
    logic        err_busy;
    logic        err_full;

    logic [15:0] cur_word;
    logic [1:0]  last_idx;
    logic        polling;
    logic        flag_set;
    logic        pc_inc;
    logic        at_limit;
    logic        unused_rd;

    assign unused_rd = ^bus_rdata;

    dsk_seq_words #(.NARG(3)) u_words (
        .cmd_code (r_cmd),
        .dev_num  (r_dev),
        .opt_byte (r_opt),
        .long_cmd (r_long),
        .arg_words(r_args),
        .idx      (widx),
        .word     (cur_word),
        .last_idx (last_idx)
    );

    // Status flag relevant to the current poll phase.
    always_comb begin
        polling  = (st == S_WAIT_IDLE) || (st == S_WAIT_TAKEN);
        flag_set = (st == S_WAIT_IDLE) ? bus_rdata[STAT_BUSY_BIT]
                                       : bus_rdata[STAT_CFULL_BIT];
        pc_inc   = polling && bus_ack && flag_set && !at_limit;
    end

    dsk_seq_pollctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!polling),
        .inc     (pc_inc),
        .at_limit(at_limit)
    );

    // Sequencer state, latched fields, word index and error causes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            r_cmd    <= '0;
            r_dev    <= '0;
            r_opt    <= '0;
            r_long   <= 1'b0;
            r_attn   <= '0;
            r_skip   <= 1'b0;
            r_aonly  <= 1'b0;
            r_args   <= '0;
            widx     <= '0;
            err_busy <= 1'b0;
            err_full <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    r_cmd    <= cmd_code;
                    r_dev    <= dev_num;
                    r_opt    <= opt_byte;
                    r_long   <= long_cmd;
                    r_attn   <= attn_type;
                    r_skip   <= skip_wait;
                    r_aonly  <= attn_only;
                    r_args   <= arg_words;
                    widx     <= '0;
                    err_busy <= 1'b0;
                    err_full <= 1'b0;
                    st       <= S_IRQ_OFF;
                end
                S_IRQ_OFF: if (bus_ack) st <= r_skip ? S_ATTN : S_WAIT_IDLE;
                S_WAIT_IDLE: if (bus_ack) begin
                    if (!flag_set)     st <= S_ATTN;
                    else if (at_limit) begin
                        err_busy <= 1'b1;
                        st       <= S_FIN;
                    end
                end
                S_ATTN:   if (bus_ack) st <= S_IRQ_ON;
                S_IRQ_ON: if (bus_ack) st <= r_aonly ? S_FIN : S_WORD;
                S_WORD:   if (bus_ack) st <= S_WAIT_TAKEN;
                S_WAIT_TAKEN: if (bus_ack) begin
                    if (!flag_set) begin
                        if (widx == last_idx) st <= S_FIN;
                        else begin
                            widx <= widx + 1'b1;
                            st   <= S_WORD;
                        end
                    end else if (at_limit) begin
                        err_full <= 1'b1;
                        st       <= S_FIN;
                    end
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Register bus access implied by the current state.
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_word  = 1'b0;
        bus_addr  = RA_CTRL;
        bus_wdata = '0;
        unique case (st)
            S_IRQ_OFF:    bus_wdata = {8'h00, CTRL_IRQ_OFF};
            S_WAIT_IDLE,
            S_WAIT_TAKEN: begin
                bus_we   = 1'b0;
                bus_addr = RA_STAT;
            end
            S_ATTN: begin
                bus_addr  = RA_ATTN;
                bus_wdata = {8'h00, r_dev, r_attn};
            end
            S_IRQ_ON:     bus_wdata = {8'h00, CTRL_IRQ_ON};
            S_WORD: begin
                bus_addr  = RA_CMDW;
                bus_word  = 1'b1;
                bus_wdata = cur_word;
            end
            default: begin
                bus_req = 1'b0;
                bus_we  = 1'b0;
            end
        endcase
    end

    // Completion and cause reporting.
    assign active  = (st != S_IDLE);
    assign done    = (st == S_FIN);
    assign busy_to = done && err_busy;
    assign cmd_to  = done && err_full;
endmodule

// File: rtl/dsk_cmd_seq_chk.sv
// Property checker for the command issue sequencer, attached by bind.
// Observes only ports of the sequencer.
module dsk_cmd_seq_chk
    import dsk_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_we,
    input logic        bus_word,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        bus_ack,
    input logic        active,
    input logic        done,
    input logic        busy_to,
    input logic        cmd_to
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !bus_req && !done && !active); // R1

    AST_FIRST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> bus_req && bus_we && bus_addr == RA_CTRL && bus_wdata == 16'h0000); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_CAUSE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_to || cmd_to) |-> done && !(busy_to && cmd_to)); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R12

    AST_SIZE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_word == (bus_we && bus_addr == RA_CMDW)); // R12

    AST_DONE_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> active && !bus_req); // R10
endmodule

bind dsk_cmd_seq dsk_cmd_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .active   (active),
    .done     (done),
    .busy_to  (busy_to),
    .cmd_to   (cmd_to)
);

// File: tb/sim_dsk_cmd_seq.sv
// Bench for the command issue sequencer: status-register model with
// programmable busy/full read counts, random acknowledge stalls, and
// expected bus traffic computed by bench functions.
module sim_dsk_cmd_seq;
    localparam int LIM = 10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  cmd_code = '0;
    logic [2:0]  dev_num = '0;
    logic [7:0]  opt_byte = '0;
    logic        long_cmd = 1'b0;
    logic [4:0]  attn_type = '0;
    logic        skip_wait = 1'b0;
    logic        attn_only = 1'b0;
    logic [47:0] arg_words = '0;
    logic        bus_req, bus_we, bus_word;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_ack;
    logic [7:0]  bus_rdata;
    logic        active, done, busy_to, cmd_to;

    always #4 clk = ~clk;

    dsk_cmd_seq #(.POLL_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
        .dev_num(dev_num), .opt_byte(opt_byte), .long_cmd(long_cmd),
        .attn_type(attn_type), .skip_wait(skip_wait), .attn_only(attn_only),
        .arg_words(arg_words), .bus_req(bus_req), .bus_we(bus_we),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .active(active),
        .done(done), .busy_to(busy_to), .cmd_to(cmd_to)
    );

    // Register bus model state.
    logic ack_en = 1'b1;
    int   busy_left = 0;
    int   full_left = 0;
    int   fplan [4];
    int   widx_m = 0;
    int   nrd = 0;
    int   nwr = 0;
    logic [1:0]  la [16];
    logic [15:0] ld [16];
    logic        lw [16];
    int   done_cnt = 0;

    int n_chk = 0;
    int n_fail = 0;

    assign bus_ack   = bus_req && ack_en;
    assign bus_rdata = {6'b0, full_left != 0, busy_left != 0};

    always @(negedge clk) ack_en <= ($urandom % 4) != 0;

    // Log accepted accesses and count down the modelled busy/full reads.
    always @(posedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        if (bus_req && bus_ack) begin
            if (bus_we) begin
                if (nwr < 16) begin
                    la[nwr] <= bus_addr;
                    ld[nwr] <= bus_wdata;
                    lw[nwr] <= bus_word;
                end
                nwr <= nwr + 1;
                if (bus_addr == 2'd3) begin
                    full_left <= fplan[widx_m];
                    widx_m    <= widx_m + 1;
                end
            end else begin
                nrd <= nrd + 1;
                if (busy_left > 0) busy_left <= busy_left - 1;
                if (full_left > 0) full_left <= full_left - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word0(logic [4:0] c, logic [2:0] d, logic [7:0] o, bit l);
        logic [15:0] w;
        w = {o, 8'h00} | {8'h00, d, c};
        if (l) w = w | 16'h4000;
        return w;
    endfunction

    function automatic int reads_for(int n);
        return (n < LIM) ? n + 1 : LIM;
    endfunction

    task automatic run_cmd(input logic [4:0] c, input logic [2:0] d, input logic [7:0] o,
                           input bit l, input logic [4:0] at, input bit sk, input bit ao,
                           input logic [47:0] aw, input int bz,
                           input int f0, input int f1, input int f2, input int f3,
                           input bit poke);
        logic [1:0]  ea [8];
        logic [15:0] ed [8];
        logic        ew [8];
        int ne, er, nw, seen_bto, seen_cto, done0;
        bit ebto, ecto;
        int fl [4];
        fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
        @(negedge clk);
        busy_left = bz; full_left = 0; widx_m = 0; nrd = 0; nwr = 0;
        for (int i = 0; i < 4; i++) fplan[i] = fl[i];
        done0 = done_cnt;
        cmd_code = c; dev_num = d; opt_byte = o; long_cmd = l; attn_type = at;
        skip_wait = sk; attn_only = ao; arg_words = aw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(active == 1'b1, "R10 active after start", active, 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            cmd_code = ~c; dev_num = ~d; long_cmd = ~l; attn_only = ~ao; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        seen_bto = busy_to; seen_cto = cmd_to;
        @(negedge clk);
        chk(done == 1'b0 && active == 1'b0, "R10 done one cycle", {done, active}, 0);
        chk(done_cnt - done0 == 1, poke ? "R11 single done" : "R10 single done", done_cnt - done0, 1);
        // Expected traffic.
        ne = 0; er = 0; ebto = 0; ecto = 0;
        ea[ne] = 2'd0; ed[ne] = 16'h0000; ew[ne] = 0; ne++;
        if (!sk) begin
            er = reads_for(bz);
            if (bz >= LIM) ebto = 1;
        end
        if (!ebto) begin
            ea[ne] = 2'd2; ed[ne] = {8'h00, d, at}; ew[ne] = 0; ne++;
            ea[ne] = 2'd0; ed[ne] = 16'h0001; ew[ne] = 0; ne++;
            if (!ao) begin
                nw = l ? 4 : 2;
                for (int k = 0; k < nw; k++) begin
                    ea[ne] = 2'd3; ew[ne] = 1;
                    ed[ne] = (k == 0) ? exp_word0(c, d, o, l) : aw[16*k-1 -: 16];
                    ne++;
                    er += reads_for(fl[k]);
                    if (fl[k] >= LIM) begin ecto = 1; break; end
                end
            end
        end
        chk(seen_bto == ebto, "R3 busy timeout flag", seen_bto, ebto);
        chk(seen_cto == ecto, "R8 command timeout flag", seen_cto, ecto);
        chk(nwr == ne, ao ? "R9 write count" : (ebto ? "R3 write count" : "R7 write count"), nwr, ne);
        chk(nrd == er, sk ? "R4 status read count" : "R2 status read count", nrd, er);
        for (int i = 0; i < ne && i < nwr; i++) begin
            string t;
            t = (ea[i] == 2'd2) ? "R5 attention byte" :
                (ea[i] == 2'd3) ? ((i == 3) ? "R6 word0" : "R7 argument word") : "R2 control write";
            chk(la[i] == ea[i] && ld[i] == ed[i] && lw[i] == ew[i], t,
                {lw[i], la[i], ld[i]}, {ew[i], ea[i], ed[i]});
        end
    endtask

    initial begin
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        chk(bus_req == 0 && done == 0 && active == 0 && busy_to == 0 && cmd_to == 0,
            "R1 reset state", {bus_req, done, active, busy_to, cmd_to}, 0);
        rst_n = 1'b1;
        // Directed corner cases.
        run_cmd(5'h01, 3'd1, 8'h02, 1, 5'h01, 0, 0, 48'h3333_2222_1111, 3, 0, 1, 2, 0, 0);
        run_cmd(5'h02, 3'd0, 8'h02, 0, 5'h01, 0, 0, 48'h0000_0000_00AA, 0, 0, 0, 0, 0, 0);
        run_cmd(5'h09, 3'd7, 8'h00, 0, 5'h02, 1, 1, 48'h0, 50, 0, 0, 0, 0, 0);  // R4 R9
        run_cmd(5'h0A, 3'd1, 8'hFF, 1, 5'h03, 1, 0, 48'hABCD_1234_5678, 20, 0, 0, 0, 0, 0);
        run_cmd(5'h01, 3'd0, 8'h02, 0, 5'h01, 0, 0, 48'h1, LIM - 1, 0, 0, 0, 0, 0); // R3 edge
        run_cmd(5'h01, 3'd0, 8'h02, 0, 5'h01, 0, 0, 48'h1, LIM, 0, 0, 0, 0, 0);     // R3 abort
        run_cmd(5'h02, 3'd1, 8'h02, 1, 5'h01, 0, 0, 48'h9, 0, 0, LIM - 1, 0, 0, 0); // R8 edge
        run_cmd(5'h02, 3'd1, 8'h02, 1, 5'h01, 0, 0, 48'h9, 0, 0, LIM, 0, 0, 0);     // R8 abort
        run_cmd(5'h03, 3'd2, 8'h10, 1, 5'h01, 0, 0, 48'h7777_6666_5555, 40, 2, 2, 2, 2, 1); // R11
        // Random mix.
        for (int n = 0; n < 40; n++) begin
            run_cmd(5'($urandom), 3'($urandom), 8'($urandom), 1'($urandom), 5'($urandom),
                    ($urandom % 5) == 0, ($urandom % 8) == 0,
                    {16'($urandom), 16'($urandom), 16'($urandom)},
                    $urandom % 25, $urandom % 6, $urandom % 6, $urandom % 6, $urandom % 6,
                    ($urandom % 6) == 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule